// File: doc/BRIEF.md
# Rope Memory Address Decoder

This block turns a flat word address for a woven read-only rope store into the signals that pick out one physical word. The store is made of several modules. Each module holds a number of words that is not a power of two, so the module and strand choices cannot be taken from raw address bits. Inside a module, every core carries one word per strand. The cores are wired electrically into planes of 128.

A requester drives a word address together with a one-cycle request strobe. One clock later the block presents registered results:
- a one-hot module select;
- a one-hot strand select;
- a plane index;
- a core index;
- an out-of-range flag;
- a valid strobe that marks the new result.

Between requests the outputs keep their last value. Module and strand are found with chains of compare-and-subtract stages, so the whole decode fits in a single cycle.

Top module: `rope_addr_decoder`

## Requirements
- R1: While reset is high, and on the first edge after it, valid is low and every select, index and flag output is zero.
- R2: Valid is high in exactly the cycle after a cycle in which the request strobe was high, and low otherwise.
- R3: For an in-range address A, module select bit floor(A / 6144) is the only bit set (bit 0 = first module, 6 bits wide).
- R4: For an in-range address A, strand select bit floor((A mod 6144) / 512) is the only bit set (bit 0 = first strand, 12 bits wide).
- R5: For an in-range address A, the core index equals A mod 128 and the plane index equals floor((A mod 512) / 128).
- R6: An address of 36864 or more sets the out-of-range flag and drives both selects, the plane index and the core index to zero.
- R7: An address below 36864 clears the out-of-range flag, and each select vector then has exactly one bit set.
- R8: In a cycle without a request, the select, index and flag outputs keep their previous values whatever the address input carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe; samples addr_i |
| addr_i | input | 16 | Linear word address |
| vld_o | output | 1 | Result valid, one cycle after request |
| mod_sel_o | output | 6 | One-hot module select |
| strand_sel_o | output | 12 | One-hot strand select |
| plane_o | output | 2 | Plane index within module |
| core_o | output | 7 | Core index within plane |
| oor_o | output | 1 | Address beyond store capacity |

## Verification
Every result sits behind a single register, so the decoded fields, the out-of-range flag and valid all appear at the first rising edge after the request. The bench drives inputs on falling edges and samples on the next falling edge. That is half a cycle after the register loads, when the result must already be present. In back-to-back bursts, each sample is compared with the address driven one cycle earlier. The hold requirement is checked one and two idle cycles after a request while the address input keeps changing.

// File: rtl/rope_pkg.sv
package rope_pkg;
  localparam int ROPE_MODULES   = 6;
  localparam int ROPE_STRANDS   = 12;
  localparam int ROPE_PLANES    = 4;
  localparam int ROPE_CORES     = 128;
  localparam int ROPE_ADDR_W    = 16;
endpackage

// File: rtl/rope_div_chain.sv
// Unrolled compare-and-subtract divider for a small bounded quotient.
// The quotient comes out one-hot; the remainder is truncated to REM_W.
module rope_div_chain #(
  parameter int NUM_W   = 16,
  parameter int DIVISOR = 6144,
  parameter int STAGES  = 5,
  parameter int REM_W   = 13
) (
  input  logic [NUM_W-1:0] num_i,
  output logic [STAGES:0]  sel_o,
  output logic [REM_W-1:0] rem_o
);
  localparam logic [NUM_W-1:0] DIV_V = NUM_W'(DIVISOR);

  logic [NUM_W-1:0] rem [STAGES+1];
  logic [STAGES-1:0] took;

  assign rem[0] = num_i;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    assign took[k]   = rem[k] >= DIV_V;
    assign rem[k+1]  = took[k] ? rem[k] - DIV_V : rem[k];
  end

  // took is a thermometer code (remainder only shrinks); edge = quotient
  assign sel_o[0] = ~took[0];
  for (genvar q = 1; q < STAGES; q++) begin : g_sel
    assign sel_o[q] = took[q-1] & ~took[q];
  end
  assign sel_o[STAGES] = took[STAGES-1];

  assign rem_o = REM_W'(rem[STAGES]);
endmodule

// File: rtl/rope_addr_decoder.sv
module rope_addr_decoder
  import rope_pkg::*;
#(
  parameter int NUM_MODS        = ROPE_MODULES,
  parameter int STRANDS         = ROPE_STRANDS,
  parameter int PLANES          = ROPE_PLANES,
  parameter int CORES_PER_PLANE = ROPE_CORES,
  parameter int ADDR_W          = ROPE_ADDR_W,
  localparam int CORE_W         = $clog2(CORES_PER_PLANE),
  localparam int PLANE_W        = $clog2(PLANES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                vld_o,
  output logic [NUM_MODS-1:0] mod_sel_o,
  output logic [STRANDS-1:0]  strand_sel_o,
  output logic [PLANE_W-1:0]  plane_o,
  output logic [CORE_W-1:0]   core_o,
  output logic                oor_o
);
  localparam int WORDS_PER_STRAND = CORES_PER_PLANE * PLANES;
  localparam int WORDS_PER_MOD    = WORDS_PER_STRAND * STRANDS;
  localparam int TOTAL_WORDS      = WORDS_PER_MOD * NUM_MODS;
  localparam int OFF_W            = $clog2(WORDS_PER_MOD);
  localparam int SPAN_W           = $clog2(WORDS_PER_STRAND);

  logic                in_rng;
  logic [NUM_MODS-1:0] mod_hot;
  logic [STRANDS-1:0]  str_hot;
  logic [OFF_W-1:0]    mod_off;
  logic [SPAN_W-1:0]   str_off;

  assign in_rng = 32'(addr_i) < TOTAL_WORDS;

  // Stage A: which module, and the offset inside it
  rope_div_chain #(
    .NUM_W(ADDR_W), .DIVISOR(WORDS_PER_MOD),
    .STAGES(NUM_MODS-1), .REM_W(OFF_W)
  ) i_mod_div (
    .num_i(addr_i), .sel_o(mod_hot), .rem_o(mod_off)
  );

  // Stage B: which strand, and the core/plane offset inside it
  rope_div_chain #(
    .NUM_W(OFF_W), .DIVISOR(WORDS_PER_STRAND),
    .STAGES(STRANDS-1), .REM_W(SPAN_W)
  ) i_str_div (
    .num_i(mod_off), .sel_o(str_hot), .rem_o(str_off)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o        <= 1'b0;
      mod_sel_o    <= '0;
      strand_sel_o <= '0;
      plane_o      <= '0;
      core_o       <= '0;
      oor_o        <= 1'b0;
    end else begin
      vld_o <= req_i;
      if (req_i) begin
        oor_o        <= ~in_rng;
        mod_sel_o    <= in_rng ? mod_hot : '0;
        strand_sel_o <= in_rng ? str_hot : '0;
        core_o       <= in_rng ? str_off[CORE_W-1:0] : '0;
        plane_o      <= in_rng ? str_off[CORE_W +: PLANE_W] : '0;
      end
    end
  end
endmodule

// File: rtl/rope_addr_decoder_chk.sv
module rope_addr_decoder_chk #(
  parameter int NUM_MODS        = 6,
  parameter int STRANDS         = 12,
  parameter int PLANES          = 4,
  parameter int CORES_PER_PLANE = 128,
  parameter int ADDR_W          = 16,
  localparam int CORE_W         = $clog2(CORES_PER_PLANE),
  localparam int PLANE_W        = $clog2(PLANES)
) (
  input logic                clk,
  input logic                rst,
  input logic                req_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                vld_o,
  input logic [NUM_MODS-1:0] mod_sel_o,
  input logic [STRANDS-1:0]  strand_sel_o,
  input logic [PLANE_W-1:0]  plane_o,
  input logic [CORE_W-1:0]   core_o,
  input logic                oor_o
);
  localparam int TOTAL_WORDS = CORES_PER_PLANE * PLANES * STRANDS * NUM_MODS;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!vld_o && !oor_o && mod_sel_o == '0 && strand_sel_o == '0
             && plane_o == '0 && core_o == '0));

  assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    req_i |=> vld_o);

  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> !vld_o);

  assert_core_low_bits_R5: assert property (@(posedge clk) disable iff (rst)
    (req_i && 32'(addr_i) < TOTAL_WORDS) |=> core_o == $past(addr_i[CORE_W-1:0]));

  assert_oor_blank_R6: assert property (@(posedge clk) disable iff (rst)
    (req_i && 32'(addr_i) >= TOTAL_WORDS) |=>
      (oor_o && mod_sel_o == '0 && strand_sel_o == '0 && plane_o == '0 && core_o == '0));

  assert_inrange_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    (req_i && 32'(addr_i) < TOTAL_WORDS) |=>
      (!oor_o && $countones(mod_sel_o) == 1 && $countones(strand_sel_o) == 1));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> ($stable(mod_sel_o) && $stable(strand_sel_o) && $stable(plane_o)
                && $stable(core_o) && $stable(oor_o)));
endmodule

bind rope_addr_decoder rope_addr_decoder_chk #(
  .NUM_MODS(NUM_MODS), .STRANDS(STRANDS), .PLANES(PLANES),
  .CORES_PER_PLANE(CORES_PER_PLANE), .ADDR_W(ADDR_W)
) i_chk (.*);

// File: tb/test_rope_addr_decoder.sv
`timescale 1ns/1ps
module test_rope_addr_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_i;
  logic [15:0] addr_i;
  logic        vld_o;
  logic [5:0]  mod_sel_o;
  logic [11:0] strand_sel_o;
  logic [1:0]  plane_o;
  logic [6:0]  core_o;
  logic        oor_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rope_addr_decoder i_rope_addr_decoder (
    .clk(clk), .rst(rst), .req_i(req_i), .addr_i(addr_i), .vld_o(vld_o),
    .mod_sel_o(mod_sel_o), .strand_sel_o(strand_sel_o), .plane_o(plane_o),
    .core_o(core_o), .oor_o(oor_o)
  );

  // packed {oor, module, strand, plane, core}
  function automatic logic [31:0] exp_pack(input int a);
    int m, off, s, p, c;
    if (a >= 36864) return {4'd0, 1'b1, 27'd0};
    m   = a / 6144;
    off = a % 6144;
    s   = off / 512;
    p   = (off % 512) / 128;
    c   = a % 128;
    return {4'd0, 1'b0, 6'(1 << m), 12'(1 << s), 2'(p), 7'(c)};
  endfunction

  function automatic logic [31:0] got_pack();
    return {4'd0, oor_o, mod_sel_o, strand_sel_o, plane_o, core_o};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_for(input int a);
    return (a >= 36864) ? "R6" : "R3 R4 R5 R7";
  endfunction

  function automatic logic [15:0] rnd_addr();
    if ($urandom_range(0, 3) == 0) return 16'($urandom_range(36864, 65535));
    return 16'($urandom_range(0, 36863));
  endfunction

  task automatic issue(input int a);
    @(negedge clk);
    req_i  = 1'b1;
    addr_i = 16'(a);
    @(negedge clk);
    req_i  = 1'b0;
    addr_i = rnd_addr();
    check("R2 valid after request", 32'(vld_o), 32'd1);
    check(tag_for(a), got_pack(), exp_pack(a));
  endtask

  initial begin
    int corners[12] = '{0, 127, 128, 511, 512, 6143, 6144, 30719, 36863, 36864, 40000, 65535};
    logic [31:0] prev_exp;
    int prev_a;
    void'($urandom(32'd20240607));
    rst = 1'b1; req_i = 1'b0; addr_i = '0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", 32'(vld_o), 32'd0);
    check("R1 reset outputs", got_pack(), 32'd0);
    req_i = 1'b1; addr_i = 16'd1000;   // request while in reset has no effect
    @(negedge clk);
    check("R1 reset ignores request", got_pack(), 32'd0);
    req_i = 1'b0;
    rst = 1'b0;

    foreach (corners[i]) issue(corners[i]);

    // hold: two idle cycles with a changing address (R8)
    for (int t = 0; t < 4; t++) begin
      int a = int'(rnd_addr());
      issue(a);
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        addr_i = rnd_addr();
        check("R2 valid low when idle", 32'(vld_o), 32'd0);
        check("R8 hold when idle", got_pack(), exp_pack(a));
      end
    end

    // random single requests with idle gaps
    for (int n = 0; n < 150; n++) issue(int'(rnd_addr()));

    // back-to-back burst
    @(negedge clk);
    req_i  = 1'b1;
    prev_a = int'(rnd_addr());
    addr_i = 16'(prev_a);
    for (int n = 0; n < 100; n++) begin
      int a = int'(rnd_addr());
      @(negedge clk);
      prev_exp = exp_pack(prev_a);
      check("R2 burst valid", 32'(vld_o), 32'd1);
      check(tag_for(prev_a), got_pack(), prev_exp);
      prev_a = a;
      addr_i = 16'(a);
    end
    @(negedge clk);
    req_i = 1'b0;
    check(tag_for(prev_a), got_pack(), exp_pack(prev_a));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule